// File: doc/BRIEF.md
# Event-Driven Up-Counter with Falling-Edge Compare

This block counts pulses that arrive on an asynchronous event line. It works in the system clock domain. The event line passes through a synchronizer. An 8-bit up-counter advances once for each low-to-high transition it detects. A programmable compare value is tested against the count, but only at the moment the event line returns low. When that test succeeds, the count restarts from zero and a one-clock interrupt pulse is raised. A pin left high after a rising transition therefore postpones both the clear and the interrupt until it drops.

A capture register gives software a way to read the running count without stopping it. While capture is enabled, the register follows the counter on every system clock. When capture is disabled, it keeps its last value. The copy is not tied to the moment the counter increments, so readers must tolerate a stale value when the count wraps between FFh and 00h. A run enable freezes the counter at zero when it is low.

Top module: `evc_event_counter`

## Requirements
- R1: After reset, cap_o reads 00h, irq_o is low and the internal count is 00h.
- R2: Each rising transition of event_i adds one to the count. With cap_en_i high, the new value shows on cap_o after the fourth rising clock edge that follows the input change. After the third edge cap_o still shows the old value.
- R3: The compare test runs only when event_i falls. If the count equals cmp_i at that moment, the count becomes 00h. While event_i stays high, no clear and no interrupt happen, even when the count already equals cmp_i.
- R4: irq_o is a single-clock pulse. It goes high after the third rising clock edge that follows the falling input change, and it is low one clock later.
- R5: Without a match the count wraps from FFh to 00h and raises no interrupt.
- R6: While run_i is low, the count is held at 00h, event transitions are ignored and irq_o stays low.
- R7: A new cmp_i value applies at the next falling-edge test, including a value written while event_i is high.
- R8: With cap_en_i high, cap_o loads the count on every clock. With cap_en_i low, cap_o holds its value.
- R9: Event pulses whose high and low phases each last at least 4 clock periods are all counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Counter run enable |
| event_i | input | 1 | Asynchronous external event line |
| cap_en_i | input | 1 | Auto-capture enable |
| cmp_i | input | 8 | Compare value |
| cap_o | output | 8 | Capture register read port |
| irq_o | output | 1 | Match interrupt pulse |

## Verification
An input change reaches the internal count through two synchronizer flops and an edge register. The count therefore changes at the third rising clock edge, and cap_o follows one edge later. The interrupt has the same three-edge latency counted from the falling input change. The bench drives inputs on falling clock edges and counts rising edges explicitly. It samples cap_o just before and just after the fourth edge, and it samples irq_o after the third and the fourth edge. A monitor samples irq_o on every falling edge to count pulses and to catch any pulse longer than one clock.

// File: rtl/evc_pkg.sv
package evc_pkg;
  localparam int unsigned CNT_W       = 8;
  localparam int unsigned SYNC_STAGES = 2;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_INC   = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_STOP  = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/evc_edge_detect.sv
module evc_edge_detect #(
  parameter int unsigned STAGES = evc_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[LAST];
  end

  assign rise_o = sync_q[LAST] & ~prev_q;
  assign fall_o = ~sync_q[LAST] & prev_q;
endmodule

// File: rtl/evc_counter.sv
module evc_counter
  import evc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic rise_i,
  input  logic fall_i,
  input  cnt_t cmp_i,
  output cnt_t cnt_o,
  output logic irq_o
);
  cnt_t     cnt_q;
  logic     irq_q;
  cnt_act_e act;

  // compare only at falling edge; increments cannot coincide with it
  always_comb begin
    if (!run_i)                          act = ACT_STOP;
    else if (fall_i && (cnt_q == cmp_i)) act = ACT_CLEAR;
    else if (rise_i)                     act = ACT_INC;
    else                                 act = ACT_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= (act == ACT_CLEAR);
      unique case (act)
        ACT_STOP,
        ACT_CLEAR: cnt_q <= '0;
        ACT_INC:   cnt_q <= cnt_q + cnt_t'(1);
        default:   cnt_q <= cnt_q;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R4
  a_r4_irq_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R3
  a_r3_irq_needs_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(fall_i) && $past(run_i));
  // R3
  a_r3_clear_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && fall_i && (cnt_q == cmp_i) |=> (cnt_q == '0) && irq_q);
  // R2
  a_r2_step_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && rise_i |=> cnt_q == $past(cnt_q) + cnt_t'(1));
  // R6
  a_r6_stopped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && !irq_q);
  // R3
  a_r3_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !rise_i && !fall_i |=> $stable(cnt_q));
endmodule

// File: rtl/evc_capture.sv
module evc_capture
  import evc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  cnt_t cnt_i,
  output cnt_t cap_o
);
  cnt_t cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cap_q <= '0;
    else if (en_i) cap_q <= cnt_i;
  end

  assign cap_o = cap_q;

  // R8
  a_r8_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cap_q == $past(cnt_i));
  // R8
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cap_q));
endmodule

// File: rtl/evc_event_counter.sv
module evc_event_counter
  import evc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             event_i,
  input  logic             cap_en_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             irq_o
);
  logic rise, fall;
  cnt_t cnt;

  evc_edge_detect #(.STAGES(SYNC_STAGES)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (event_i),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  evc_counter u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .rise_i (rise),
    .fall_i (fall),
    .cmp_i  (cmp_i),
    .cnt_o  (cnt),
    .irq_o  (irq_o)
  );

  evc_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_en_i),
    .cnt_i  (cnt),
    .cap_o  (cap_o)
  );

  // R1
  a_r1_irq_quiet_in_reset: assert property (@(posedge clk_i)
    !rst_ni |-> !irq_o);
endmodule

// File: tb/evc_event_counter_tb.sv
module evc_event_counter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       ev = 1'b0;
  logic       cap_en = 1'b0;
  logic [7:0] cmp = 8'd200;
  logic [7:0] cap;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int irq_seen = 0;
  logic irq_prev = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  evc_event_counter dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .run_i    (run),
    .event_i  (ev),
    .cap_en_i (cap_en),
    .cmp_i    (cmp),
    .cap_o    (cap),
    .irq_o    (irq)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // R4: pulse count and width monitor
  always @(negedge clk) begin
    if (rst_n && irq) irq_seen++;
    if (rst_n && irq && irq_prev) begin
      n_chk++; n_bad++;
      $display("FAIL R4: irq high on 2 samples, got 2 expected 1");
    end
    irq_prev <= irq;
  end

  task automatic pulse(int hi, int lo);
    ev = 1'b1;
    repeat (hi) @(negedge clk);
    ev = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 cap", cap, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic t_latency();
    ev = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 before 4th edge", cap, 0);
    @(negedge clk);
    check("R2 after 4th edge", cap, 1);
    repeat (4) @(negedge clk);
    ev = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 one count", cap, 1);
  endtask

  task automatic t_min_width();
    for (int i = 0; i < 4; i++) pulse(4, 4);
    repeat (4) @(negedge clk);
    check("R9 min width pulses", cap, 5);
  endtask

  task automatic t_deferred();
    int base = irq_seen;
    cmp = 8'd7;
    pulse(6, 6);
    ev = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 held high count", cap, 7);
    check("R3 no irq while high", irq_seen - base, 0);
    ev = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 irq after 3rd edge", irq, 1);
    @(negedge clk);
    check("R4 irq low next", irq, 0);
    check("R3 cleared", cap, 0);
    check("R4 one pulse", irq_seen - base, 1);
  endtask

  task automatic t_cmp_change();
    int base = irq_seen;
    cmp = 8'd10;
    pulse(5, 5);
    pulse(5, 5);
    ev = 1'b1;
    repeat (6) @(negedge clk);
    cmp = 8'd3;
    repeat (3) @(negedge clk);
    check("R7 no irq before fall", irq_seen - base, 0);
    ev = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 new cmp applied", irq_seen - base, 1);
    check("R7 cleared", cap, 0);
  endtask

  task automatic t_wrap();
    int base = irq_seen;
    cmp = 8'd250;
    for (int i = 0; i < 249; i++) pulse(4, 4);
    repeat (4) @(negedge clk);
    check("R5 count 249", cap, 249);
    cmp = 8'd3;
    for (int i = 0; i < 9; i++) pulse(4, 4);
    repeat (4) @(negedge clk);
    check("R5 wrapped count", cap, 2);
    check("R5 no irq on wrap", irq_seen - base, 0);
  endtask

  task automatic t_stopped();
    int base = irq_seen;
    run = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 held zero", cap, 0);
    cmp = 8'd0;
    for (int i = 0; i < 3; i++) pulse(5, 5);
    check("R6 edges ignored", cap, 0);
    check("R6 no irq", irq_seen - base, 0);
    cmp = 8'd200;
    run = 1'b1;
    repeat (2) @(negedge clk);
    pulse(5, 5);
    pulse(5, 5);
    check("R6 restart count", cap, 2);
  endtask

  task automatic t_capture_hold();
    cap_en = 1'b0;
    for (int i = 0; i < 3; i++) pulse(5, 5);
    check("R8 held while off", cap, 2);
    cap_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 reload", cap, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run = 1'b1;
    cap_en = 1'b1;
    repeat (2) @(negedge clk);
    t_latency();
    t_min_width();
    t_deferred();
    t_cmp_change();
    t_wrap();
    t_stopped();
    t_capture_hold();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule